// File: doc/BRIEF.md
# USB2 Host Port Status and Control Register

This block holds the status and control word of one high-speed host port. Software reads a 32-bit word and writes it whole under a single write strobe. The hardware side supplies four things: the level of the attached-device detect, the level of the port overcurrent detect, the controller's configured flag and a host-controller reset. Both detect levels pass through a synchronizer chain. They then appear in the word as read-only status bits.

The block watches the synchronized connect level and the overcurrent level for edges. When a matching enable is set, a connect, a disconnect or a rising overcurrent raises a one-cycle wake pulse toward the power-management logic. The stored test-selection code goes out to the port signalling logic, with a flag that marks reserved codes. When the configured flag rises, the block takes ownership of the port back from the companion controller by clearing the owner bit.

Top module: `usb_port_ctl`

## Requirements
- R1: Bits 31:23 of the read word are always 0, whatever was written to them.
- R2: After power-on reset the read word is 0x0000_2000: owner (bit 13) is 1 and every other bit is 0. The wake pulse is 0, the test code output is 0 and the reserved flag is 0.
- R3: A write stores data bits 22:13 as written: wake enables 22:20, test code 19:16, spare 15:14 and owner 13. Software reads them back at the same positions from the next cycle on.
- R4: Bit 0 shows the connect input SYNC_STAGES cycles after the input changes. Software writes to bit 0 have no effect on it.
- R5: Bit 4 shows the overcurrent input SYNC_STAGES cycles after the input changes. Bits 12:5 and 3:1 always read 0, so the port reads as disabled. Software writes to bits 4:0 and 12:5 have no effect.
- R6: When bit 20 is set, a 0-to-1 change of bit 0 raises the wake pulse for exactly one cycle, SYNC_STAGES+1 cycles after the input change. When bit 20 is clear, no pulse is raised.
- R7: When bit 21 is set, a 1-to-0 change of bit 0 raises one single-cycle wake pulse with the same latency. When bit 21 is clear, no pulse is raised.
- R8: When bit 22 is set, a 0-to-1 change of bit 4 raises one single-cycle wake pulse with the same latency. A 1-to-0 change of bit 4 never raises a pulse.
- R9: Enabled events that occur in the same cycle together produce one single-cycle pulse.
- R10: In the cycle after the configured flag rises from 0 to 1, the owner bit and output are 0, even if a write of owner=1 happens in the same cycle. A flag held high does not block later writes to the owner bit.
- R11: For stored test codes 0 to 5 (0 none, 1 J, 2 K, 3 SE0/NAK, 4 packet, 5 force enable), the test code output equals the code and the reserved flag is 0. For codes 6 to 15 the output is 0, the reserved flag is 1, and bits 19:16 still read the stored value.
- R12: A one-cycle host-controller reset returns the word to 0x0000_2000 in the next cycle. This shows no device connected and clears the synchronizers. No wake pulse comes from the connect status being rebuilt after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hc_reset | input | 1 | Synchronous host-controller reset, active high |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| connect_in | input | 1 | Device attached level, asynchronous |
| ovc_in | input | 1 | Overcurrent active level, asynchronous |
| cfg_flag | input | 1 | Configured flag from the controller command logic |
| pme_set | output | 1 | One-cycle wake request pulse |
| tmode_code | output | 4 | Active test code, 0 when none or reserved |
| tmode_rsvd | output | 1 | Stored test code is a reserved value |
| owner | output | 1 | Port owner bit, 1 = companion controller |

## Verification
The bench builds the block with SYNC_STAGES = 2. With that setting the synchronizer generate path is a real chain of more than one flop. Read-back latency (two cycles) and wake-pulse latency (three cycles) are then distinct, so a pulse that comes one cycle early or late, or that shows up on the status read at the wrong time, can be seen. A one-stage build would hide an off-by-one between the chain and the edge register.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CTL_LSB   = 13;
  localparam int unsigned CTL_MSB   = 22;
  localparam int unsigned TEST_W    = 4;
  localparam int unsigned LEGAL_MAX = 5;

  // field order matches word bits 22 down to 13
  typedef struct packed {
    logic              wk_oc;
    logic              wk_dis;
    logic              wk_con;
    logic [TEST_W-1:0] test;
    logic [1:0]        spare;
    logic              owner;
  } port_ctl_t;

  typedef enum logic [TEST_W-1:0] {
    TM_OFF    = 4'd0,
    TM_J      = 4'd1,
    TM_K      = 4'd2,
    TM_SE0NAK = 4'd3,
    TM_PACKET = 4'd4,
    TM_FORCE  = 4'd5
  } tmode_e;

  localparam port_ctl_t CTL_DEFAULT = '{
    wk_oc: 1'b0, wk_dis: 1'b0, wk_con: 1'b0,
    test: TM_OFF, spare: 2'b00, owner: 1'b1
  };

  function automatic logic tmode_legal(input logic [TEST_W-1:0] c);
    return c <= TEST_W'(LEGAL_MAX);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input port_ctl_t c,
                                                  input logic conn,
                                                  input logic ovc);
    return {9'd0, c, 8'd0, ovc, 3'd0, conn};
  endfunction

  function automatic logic wake_any(input logic en_con, input logic en_dis,
                                    input logic en_oc, input logic c_rise,
                                    input logic c_fall, input logic o_rise);
    return (en_con & c_rise) | (en_dis & c_fall) | (en_oc & o_rise);
  endfunction

endpackage

// File: rtl/usb_port_sync.sv
module usb_port_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic level,
  output logic prev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain <= '0;
        else if (clr) chain <= '0;
        else          chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain <= '0;
        else if (clr) chain <= '0;
        else          chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev <= 1'b0;
    else if (clr) prev <= 1'b0;
    else          prev <= level;
  end
endmodule

// File: rtl/usb_port_ctl_reg.sv
module usb_port_ctl_reg
  import usb_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      wr_en,
  input  port_ctl_t wr_fields,
  input  logic      cfg_flag,
  output port_ctl_t ctl,
  output logic      cfg_rise
);
  logic cfg_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_prev <= 1'b0;
    else        cfg_prev <= cfg_flag;
  end

  assign cfg_rise = cfg_flag & ~cfg_prev;

  // ownership hand-back is placed last so it overrides a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_DEFAULT;
    end else if (clr) begin
      ctl <= CTL_DEFAULT;
    end else begin
      if (wr_en)    ctl       <= wr_fields;
      if (cfg_rise) ctl.owner <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_port_wake.sv
module usb_port_wake
  import usb_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_con,
  input  logic en_dis,
  input  logic en_oc,
  input  logic conn_lvl,
  input  logic conn_prev,
  input  logic ovc_lvl,
  input  logic ovc_prev,
  output logic conn_rise,
  output logic conn_fall,
  output logic ovc_rise,
  output logic wake_evt,
  output logic pme_set
);
  assign conn_rise = conn_lvl & ~conn_prev;
  assign conn_fall = ~conn_lvl & conn_prev;
  assign ovc_rise  = ovc_lvl & ~ovc_prev;
  assign wake_evt  = wake_any(en_con, en_dis, en_oc, conn_rise, conn_fall, ovc_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pme_set <= 1'b0;
    else if (clr) pme_set <= 1'b0;
    else          pme_set <= wake_evt;
  end
endmodule

// File: rtl/usb_port_tmode.sv
module usb_port_tmode
  import usb_port_pkg::*;
(
  input  logic [TEST_W-1:0] stored,
  output logic [TEST_W-1:0] code,
  output logic              rsvd
);
  logic legal;
  assign legal = tmode_legal(stored);
  assign rsvd  = ~legal;
  assign code  = legal ? stored : TEST_W'(TM_OFF);
endmodule

// File: rtl/usb_port_ctl.sv
module usb_port_ctl
  import usb_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hc_reset,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        connect_in,
  input  logic        ovc_in,
  input  logic        cfg_flag,
  output logic        pme_set,
  output logic [3:0]  tmode_code,
  output logic        tmode_rsvd,
  output logic        owner
);
  port_ctl_t ctl_q;
  port_ctl_t wr_fields;
  logic conn_lvl, conn_prev, ovc_lvl, ovc_prev;
  logic conn_rise, conn_fall, ovc_rise, wake_evt, cfg_rise;

  assign wr_fields = port_ctl_t'(wr_data[CTL_MSB:CTL_LSB]);

  usb_port_sync #(.STAGES(SYNC_STAGES)) u_conn_sync (
    .clk(clk), .rst_n(rst_n), .clr(hc_reset), .d(connect_in),
    .level(conn_lvl), .prev(conn_prev)
  );

  usb_port_sync #(.STAGES(SYNC_STAGES)) u_ovc_sync (
    .clk(clk), .rst_n(rst_n), .clr(hc_reset), .d(ovc_in),
    .level(ovc_lvl), .prev(ovc_prev)
  );

  usb_port_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .clr(hc_reset), .wr_en(wr_en),
    .wr_fields(wr_fields), .cfg_flag(cfg_flag),
    .ctl(ctl_q), .cfg_rise(cfg_rise)
  );

  usb_port_wake u_wake (
    .clk(clk), .rst_n(rst_n), .clr(hc_reset),
    .en_con(ctl_q.wk_con), .en_dis(ctl_q.wk_dis), .en_oc(ctl_q.wk_oc),
    .conn_lvl(conn_lvl), .conn_prev(conn_prev),
    .ovc_lvl(ovc_lvl), .ovc_prev(ovc_prev),
    .conn_rise(conn_rise), .conn_fall(conn_fall), .ovc_rise(ovc_rise),
    .wake_evt(wake_evt), .pme_set(pme_set)
  );

  usb_port_tmode u_tmode (
    .stored(ctl_q.test), .code(tmode_code), .rsvd(tmode_rsvd)
  );

  assign rd_data = pack_word(ctl_q, conn_lvl, ovc_lvl);
  assign owner   = ctl_q.owner;
endmodule

// File: rtl/usb_port_ctl_chk.sv
module usb_port_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hc_reset,
  input logic        cfg_rise,
  input logic        ovc_rise,
  input logic        wk_oc,
  input logic        wake_evt,
  input logic        pme_set,
  input logic        owner,
  input logic [3:0]  tmode_code,
  input logic        tmode_rsvd,
  input logic [31:0] rd_data
);
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:23] == 9'd0);

  a_r10_owner_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rise && !hc_reset) |=> !owner);

  a_r6_pme_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pme_set |-> $past(wake_evt));

  a_r8_oc_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_rise && wk_oc && !hc_reset) |=> pme_set);

  a_r11_rsvd_code: assert property (@(posedge clk) disable iff (!rst_n)
    tmode_rsvd |-> (tmode_code == 4'd0));

  a_r12_hc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hc_reset |=> (rd_data == 32'h0000_2000 && !pme_set));
endmodule

bind usb_port_ctl usb_port_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .cfg_rise(cfg_rise),
  .ovc_rise(ovc_rise), .wk_oc(ctl_q.wk_oc), .wake_evt(wake_evt),
  .pme_set(pme_set), .owner(owner), .tmode_code(tmode_code),
  .tmode_rsvd(tmode_rsvd), .rd_data(rd_data)
);

// File: tb/usb_port_ctl_tb.sv
module usb_port_ctl_tb;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hc_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        connect_in = 1'b0;
  logic        ovc_in = 1'b0;
  logic        cfg_flag = 1'b0;
  logic        pme_set;
  logic [3:0]  tmode_code;
  logic        tmode_rsvd;
  logic        owner;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  usb_port_ctl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .connect_in(connect_in),
    .ovc_in(ovc_in), .cfg_flag(cfg_flag), .pme_set(pme_set),
    .tmode_code(tmode_code), .tmode_rsvd(tmode_rsvd), .owner(owner)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic c, input logic o);
    return (w & 32'h007F_E000) | {27'd0, o, 3'd0, c};
  endfunction

  function automatic logic [3:0] exp_code(input logic [3:0] t);
    return (t < 4'd6) ? t : 4'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  // watch for pulses after an input change; expect none or exactly one at SYNC+1
  task automatic ev_check(input string req, input logic c, input logic o, input bit want);
    int cnt = 0;
    int first = 0;
    connect_in = c; ovc_in = o;
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      if (pme_set) begin
        cnt++;
        if (cnt == 1) first = k;
      end
    end
    if (want) begin
      check(req, 32'(cnt), 32'd1);
      check(req, 32'(first), 32'(SYNC + 1));
    end else begin
      check(req, 32'(cnt), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R2 reset state
    check("R2 word", rd_data, 32'h0000_2000);
    check("R2 pme", 32'(pme_set), 32'd0);
    check("R2 code", 32'(tmode_code), 32'd0);
    check("R2 rsvd", 32'(tmode_rsvd), 32'd0);

    // R1 R3 R11 all ones
    wr(32'hFFFF_FFFF);
    check("R1 R3 all ones", rd_data, 32'h007F_E000);
    check("R3 owner", 32'(owner), 32'd1);
    check("R11 reserved code", 32'(tmode_code), 32'd0);
    check("R11 reserved flag", 32'(tmode_rsvd), 32'd1);
    wr(32'h0000_0000);
    check("R3 zeros", rd_data, 32'd0);
    check("R3 owner zero", 32'(owner), 32'd0);

    // R11 legal codes
    for (int c = 0; c < 6; c++) begin
      wr(32'(c) << 16);
      check("R11 legal code", 32'(tmode_code), 32'(c));
      check("R11 legal flag", 32'(tmode_rsvd), 32'd0);
      check("R11 readback", rd_data, 32'(c) << 16);
    end

    // R4 R6 connect with all enables off
    wr(32'h0);
    ev_check("R6 disabled connect", 1'b1, 1'b0, 1'b0);
    check("R4 connect mirror", rd_data, 32'h1);
    wr(32'h0000_1FFE);
    check("R4 R5 ro writes", rd_data, 32'h1);
    wr(32'h0000_0010);
    check("R5 bit4 write ignored", rd_data, 32'h1);

    // R6 R7 connect enable only
    wr(32'h0010_0000);
    ev_check("R7 disabled disconnect", 1'b0, 1'b0, 1'b0);
    ev_check("R6 connect wake", 1'b1, 1'b0, 1'b1);
    // R7 disconnect enable only
    wr(32'h0020_0000);
    ev_check("R7 disconnect wake", 1'b0, 1'b0, 1'b1);
    ev_check("R6 connect not enabled", 1'b1, 1'b0, 1'b0);

    // R8 overcurrent
    wr(32'h0040_0000);
    ev_check("R8 oc rise wake", 1'b1, 1'b1, 1'b1);
    check("R5 oc mirror", rd_data, 32'h0040_0011);
    ev_check("R8 oc fall silent", 1'b1, 1'b0, 1'b0);

    // R9 simultaneous disconnect and overcurrent
    wr(32'h0070_0000);
    ev_check("R9 merged events", 1'b0, 1'b1, 1'b1);

    // R10 ownership hand-back
    wr(32'h0000_2000);
    check("R10 owner set", 32'(owner), 32'd1);
    cfg_flag = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_2000;
    tick(1);
    wr_en = 1'b0;
    check("R10 clear beats write", 32'(owner), 32'd0);
    check("R10 word", rd_data[13], 1'b0);
    wr(32'h0000_2000);
    check("R10 held flag allows write", 32'(owner), 32'd1);
    cfg_flag = 1'b0; tick(1);
    cfg_flag = 1'b1; tick(1);
    check("R10 second rise", 32'(owner), 32'd0);
    cfg_flag = 1'b0; tick(1);

    // R12 host-controller reset
    wr(32'h007F_C000);
    ev_check("R12 setup connect", 1'b1, 1'b1, 1'b1);
    hc_reset = 1'b1; tick(1); hc_reset = 1'b0;
    check("R12 word cleared", rd_data, 32'h0000_2000);
    check("R12 code cleared", 32'(tmode_code), 32'd0);
    ev_check("R12 no wake on rebuild", 1'b1, 1'b1, 1'b0);
    check("R12 status rebuilt", rd_data, 32'h0000_2011);

    // random writes against the read-back model, R1 R3 R4 R5 R11
    connect_in = 1'b0; ovc_in = 1'b0; tick(SYNC + 2);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 8) == 0) begin
        connect_in = $urandom; ovc_in = $urandom;
        tick(SYNC + 1);
      end
      wr(d);
      check("R1 R3 R4 R5 random word", rd_data, exp_word(d, connect_in, ovc_in));
      check("R11 random code", 32'(tmode_code), 32'(exp_code(d[19:16])));
      check("R11 random flag", 32'(tmode_rsvd), 32'(d[19:16] > 4'd5));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule